// File: doc/BRIEF.md
# BCD Watchdog Countdown Timer

This block is a watchdog whose timeout is set in two binary-coded-decimal registers. One register holds whole seconds and the other holds hundredths, so the timeout runs from 00.00 to 99.99 s. A 100 Hz tick enable drives a hidden working counter. The counter counts down from the programmed value in BCD. When it reaches zero, the block raises a sticky flag and emits a one-cycle interrupt request. It then reloads and goes on counting, so the alarm repeats until software services it.

Software services the watchdog with any read or write of either timeout register. Each such access reloads the counter, restarts the countdown and clears the flag. A timeout of 00.00 turns the watchdog off.

A three-state controller sequences the counter:
- `ST_OFF`: the timer is idle.
- `ST_LOAD`: a one-cycle reload of the counter from the registers.
- `ST_RUN`: the timer is counting ticks.

Its transitions are:
- reset → `ST_OFF`.
- any register access → `ST_LOAD`. This applies from every state and takes priority.
- `ST_LOAD` → `ST_OFF` when the timeout is zero.
- `ST_LOAD` → `ST_RUN` when the timeout is nonzero.
- `ST_RUN` → `ST_RUN` on each tick, either decrementing the counter or, on expiry, reloading it.
- `ST_OFF` → `ST_OFF` otherwise.

Top module: `bcd_wdog`

## Requirements
- R1: After reset both timeout registers read 00, `wd_flag` and `wd_irq` are low, and the timer is off.
- R2: Address 0 holds the hundredths register and address 1 holds the seconds register. Each is two BCD digits, with the tens digit in bits 7:4. While `rd_en` is high, reading either register returns the value last written. Any other address reads 00, and an access to it neither restarts the count nor clears the flag.
- R3: Take a timeout of S.H seconds and let T = S·100 + H. The flag sets on the T-th tick after a restart. The first tick that counts is the one sampled two clock edges after the access edge, and a tick sampled on the access edge or the reload edge is ignored.
- R4: The countdown borrows in BCD. A hundredths value of 00 wraps to 99 and takes one from the seconds. A low digit of 0 wraps to 9 and takes one from the tens digit.
- R5: Without any access, the counter reloads after each expiry and `wd_irq` pulses once every T ticks. `wd_flag` stays set until an access.
- R6: Any read or any write of either timeout register restarts the countdown from the programmed value. The registers may be written in either order.
- R7: An access to either timeout register clears `wd_flag` at that clock edge. It also suppresses an expiry that falls on the same edge.
- R8: While both registers hold 00, no expiry occurs and the flag stays clear.
- R9: `wd_irq` is high for exactly the one cycle after the clock edge that sampled the expiring tick. It is high only while `wd_flag` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data (BCD) |
| rd_data | output | 8 | Read data, combinational |
| tick_100hz | input | 1 | One-cycle 100 Hz count enable |
| wd_flag | output | 1 | Sticky watchdog flag |
| wd_irq | output | 1 | One-cycle interrupt request per expiry |

## Verification
The bench uses the default parameters: a 2-bit address, hundredths at address 0 and seconds at address 1. With those values, address 2 exercises an unmapped access and the full 99.99 s timeout (9999 ticks) fits in the run. The tick is driven on every cycle when needed, which makes the longest countdowns cheap to cover. That brings every BCD borrow path within reach: the hundredths wrap, the tens wrap inside the seconds register, and the wrap from 99.99 down. It also covers an access that lands on the same edge as an expiring tick.

// File: rtl/bcd_wdog_pkg.sv
package bcd_wdog_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } wd_state_e;

    // One BCD digit pair decremented by one; 00 wraps to 99.
    function automatic logic [7:0] bcd_pair_dec(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] != 4'd0)      r = {v[7:4], v[3:0] - 4'd1};
        else if (v[7:4] != 4'd0) r = {v[7:4] - 4'd1, 4'd9};
        else                     r = 8'h99;
        return r;
    endfunction

endpackage

// File: rtl/bcd_wdog_regs.sv
module bcd_wdog_regs
    import bcd_wdog_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int HUN_ADDR = 0,
    parameter int SEC_ADDR = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  rd_en,
    input  logic                  wr_en,
    input  logic [BYTE_W-1:0]     wr_data,
    output logic [BYTE_W-1:0]     rd_data,
    output logic                  access,
    output logic [2*BYTE_W-1:0]   timeout
);
    localparam int NREG = 2;

    logic [BYTE_W-1:0] reg_q [NREG];
    logic [NREG-1:0]   hit;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam int REG_ADDR = (g == 0) ? HUN_ADDR : SEC_ADDR;
        assign hit[g] = (addr == ADDR_W'(REG_ADDR));

        always_ff @(posedge clk) begin
            if (!rst_n)              reg_q[g] <= '0;
            else if (wr_en && hit[g]) reg_q[g] <= wr_data;
        end

        assign timeout[g*BYTE_W +: BYTE_W] = reg_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_en && hit[i]) rd_data = reg_q[i];
        end
    end

    assign access = (rd_en || wr_en) && (|hit);

endmodule

// File: rtl/bcd_wdog_dncnt.sv
module bcd_wdog_dncnt
    import bcd_wdog_pkg::*;
#(
    parameter int PAIRS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [PAIRS*BYTE_W-1:0]   load_val,
    input  logic                      dec,
    output logic [PAIRS*BYTE_W-1:0]   cnt
);
    localparam int W = PAIRS * BYTE_W;

    logic [W-1:0]     cnt_q;
    logic [W-1:0]     cnt_dec;
    logic [PAIRS-1:0] bor;

    assign bor[0] = 1'b1;

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        logic [BYTE_W-1:0] cur;
        assign cur = cnt_q[g*BYTE_W +: BYTE_W];
        assign cnt_dec[g*BYTE_W +: BYTE_W] = bor[g] ? bcd_pair_dec(cur) : cur;
        if (g < PAIRS - 1) begin : g_bor
            assign bor[g+1] = bor[g] && (cur == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_dec;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/bcd_wdog_ctrl.sv
module bcd_wdog_ctrl
    import bcd_wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic tick,
    input  logic timeout_zero,
    input  logic cnt_is_one,
    output logic load,
    output logic dec,
    output logic wd_flag,
    output logic wd_irq
);
    wd_state_e state_q, state_d;
    logic      fire;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = ST_OFF;
            ST_LOAD: state_d = timeout_zero ? ST_OFF : ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_OFF;
        endcase
        if (access) state_d = ST_LOAD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign fire = (state_q == ST_RUN) && tick && cnt_is_one && !access;
    assign dec  = (state_q == ST_RUN) && tick && !cnt_is_one && !access;
    assign load = (state_q == ST_LOAD) || fire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_flag <= 1'b0;
            wd_irq  <= 1'b0;
        end else begin
            wd_irq <= fire;
            if (access)    wd_flag <= 1'b0;
            else if (fire) wd_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/bcd_wdog.sv
module bcd_wdog
    import bcd_wdog_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int HUN_ADDR = 0,
    parameter int SEC_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              tick_100hz,
    output logic              wd_flag,
    output logic              wd_irq
);
    localparam int PAIRS = 2;
    localparam int TW    = PAIRS * BYTE_W;

    logic          access;
    logic [TW-1:0] timeout;
    logic [TW-1:0] cnt;
    logic          load, dec;
    logic [7:0]    hun_q, sec_q;

    bcd_wdog_regs #(
        .ADDR_W  (ADDR_W),
        .HUN_ADDR(HUN_ADDR),
        .SEC_ADDR(SEC_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .access (access),
        .timeout(timeout)
    );

    assign hun_q = timeout[7:0];
    assign sec_q = timeout[15:8];

    bcd_wdog_dncnt #(.PAIRS(PAIRS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(timeout),
        .dec     (dec),
        .cnt     (cnt)
    );

    bcd_wdog_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .access      (access),
        .tick        (tick_100hz),
        .timeout_zero(timeout == '0),
        .cnt_is_one  (cnt == TW'(1)),
        .load        (load),
        .dec         (dec),
        .wd_flag     (wd_flag),
        .wd_irq      (wd_irq)
    );

endmodule

// File: rtl/bcd_wdog_chk.sv
module bcd_wdog_chk #(
    parameter int ADDR_W   = 2,
    parameter int HUN_ADDR = 0,
    parameter int SEC_ADDR = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic              tick,
    input logic              wd_flag,
    input logic              wd_irq,
    input logic [7:0]        hun_q,
    input logic [7:0]        sec_q
);
    logic acc;
    logic tmo_zero;

    assign acc = (rd_en || wr_en) &&
                 (addr == ADDR_W'(HUN_ADDR) || addr == ADDR_W'(SEC_ADDR));
    assign tmo_zero = (hun_q == 8'h00) && (sec_q == 8'h00);

    AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (!wd_flag && !wd_irq)); // R7

    AST_FLAG_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> ($past(tick) && !$past(acc))); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_flag && !acc) |=> wd_flag); // R5

    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> (wd_flag && $past(tick))); // R9

    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_zero && $past(tmo_zero)) |-> !wd_irq); // R8

endmodule

bind bcd_wdog bcd_wdog_chk #(
    .ADDR_W  (ADDR_W),
    .HUN_ADDR(HUN_ADDR),
    .SEC_ADDR(SEC_ADDR)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .tick   (tick_100hz),
    .wd_flag(wd_flag),
    .wd_irq (wd_irq),
    .hun_q  (hun_q),
    .sec_q  (sec_q)
);

// File: tb/bcd_wdog_test.sv
`timescale 1ns/1ps
module bcd_wdog_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       tick = 1'b0;
    logic       wd_flag;
    logic       wd_irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bcd_wdog uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .tick_100hz(tick),
        .wd_flag   (wd_flag),
        .wd_irq    (wd_irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bus access, then wait through the reload cycle.
    task automatic acc(input bit rd, input logic [1:0] a, input logic [7:0] d,
                       output logic [7:0] rdat);
        @(negedge clk);
        addr = a; rd_en = rd; wr_en = !rd; wr_data = d;
        #1 rdat = rd_data;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            if (wd_irq) pulses++;
        end
    endtask

    task automatic expect_fire(input int t, input string tag);
        int p;
        ticks(t - 1, p);
        chk(!wd_flag && p == 0, {tag, " no fire before T"}, {wd_flag, p[30:0]}, 0);
        ticks(1, p);
        chk(wd_flag && p == 1, {tag, " fire at T"}, p, 1);
    endtask

    task automatic t_reset;
        logic [7:0] r;
        chk(!wd_flag && !wd_irq, "R1 reset outputs", {wd_flag, wd_irq}, 0);
        acc(1'b1, 2'd0, 8'h00, r);
        chk(r == 8'h00, "R1 hundredths reset", r, 0);
        acc(1'b1, 2'd1, 8'h00, r);
        chk(r == 8'h00, "R1 seconds reset", r, 0);
    endtask

    task automatic t_disabled;
        int p;
        ticks(200, p);
        chk(p == 0 && !wd_flag, "R8 zero timeout quiet", p, 0);
    endtask

    task automatic t_short_repeat;
        logic [7:0] r;
        int p;
        acc(1'b0, 2'd0, 8'h05, r);
        expect_fire(5, "R3 00.05");
        ticks(15, p);
        chk(p == 3, "R5 repeat pulses", p, 3);
        chk(wd_flag, "R5 flag sticky", wd_flag, 1);
    endtask

    task automatic t_read_restart;
        logic [7:0] r;
        int p;
        acc(1'b1, 2'd0, 8'h00, r);
        chk(r == 8'h05, "R2 hundredths readback", r, 8'h05);
        chk(!wd_flag, "R7 read clears flag", wd_flag, 0);
        ticks(3, p);
        acc(1'b1, 2'd1, 8'h00, r);
        chk(r == 8'h00, "R2 seconds readback", r, 0);
        expect_fire(5, "R6 read restart");
    endtask

    task automatic t_unmapped;
        logic [7:0] r;
        int p;
        ticks(3, p);
        acc(1'b1, 2'd2, 8'h00, r);
        chk(r == 8'h00, "R2 unmapped reads zero", r, 0);
        chk(wd_flag, "R2 unmapped keeps flag", wd_flag, 1);
        ticks(2, p);
        chk(p == 1, "R2 unmapped no restart", p, 1);
    endtask

    task automatic t_order_borrow;
        logic [7:0] r;
        int p;
        acc(1'b0, 2'd1, 8'h01, r);
        chk(!wd_flag, "R7 write clears flag", wd_flag, 0);
        ticks(50, p);
        acc(1'b0, 2'd0, 8'h00, r);
        expect_fire(100, "R4 R6 01.00");
    endtask

    task automatic t_long;
        logic [7:0] r;
        acc(1'b0, 2'd1, 8'h99, r);
        acc(1'b0, 2'd0, 8'h99, r);
        expect_fire(9999, "R4 99.99");
        acc(1'b0, 2'd0, 8'h00, r);
        acc(1'b0, 2'd1, 8'h10, r);
        expect_fire(1000, "R4 10.00");
    endtask

    task automatic t_collide;
        logic [7:0] r;
        int p;
        acc(1'b0, 2'd1, 8'h00, r);
        acc(1'b0, 2'd0, 8'h03, r);
        ticks(2, p);
        @(negedge clk);
        tick = 1'b1; rd_en = 1'b1; addr = 2'd0;
        @(negedge clk);
        tick = 1'b0; rd_en = 1'b0;
        chk(!wd_flag && !wd_irq, "R7 access beats expiry", {wd_flag, wd_irq}, 0);
        @(negedge clk);
        expect_fire(3, "R7 restart after collision");
    endtask

    task automatic t_zero_off;
        logic [7:0] r;
        int p;
        acc(1'b0, 2'd0, 8'h00, r);
        chk(!wd_flag, "R7 zero write clears", wd_flag, 0);
        ticks(300, p);
        chk(p == 0 && !wd_flag, "R8 disabled after zero", p, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_short_repeat();
        t_read_restart();
        t_unmapped();
        t_order_borrow();
        t_long();
        t_collide();
        t_zero_off();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule